// File: doc/BRIEF.md
# Multiplexed-Address DRAM Burst Controller

This controller sits between a simple request port and a DRAM whose row and column addresses share one set of address pins. A request carries a direction, a full word address and a beat count. The controller activates the row half of the address under a row strobe. It then issues one column access per beat under a column strobe, stepping the column by one on every beat. At the end it closes the row with a precharge gap.

A free-running interval timer asks for one row refresh at a fixed spacing, so that one pass over every row fits inside the refresh period given as a parameter. A refresh is a row activation with no column access. Its row comes from a wrapping pointer. Refresh is arbitrated against user traffic only while the controller is idle, so a burst is never split. The row-to-column delay, the read latency per beat and the precharge time are whole-cycle parameters, each enforced by a single shared down-counter. The DRAM array itself lives only in the testbench.

Top module: `dram_burst_ctrl`

## Requirements
- R1: After reset, all four strobes (`dram_ras_n`, `dram_cas_n`, `dram_we_n`, `dram_oe_n`) are high, `rd_valid` and `wr_pull` are low, and `req_ready` is high.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. In the next cycle `dram_ras_n` goes low with `dram_addr` = `req_addr[21:11]` (the row). The first column strobe comes exactly T_RCD cycles after the row strobe falls.
- R3: During a column access `dram_addr` carries the column and `dram_cas_n` is low. A write beat lasts one cycle with `dram_we_n` low, `dram_dq_oe` and `wr_pull` high, and `dram_dq_out` = `wr_data`. A read beat holds `dram_oe_n` low for T_CL cycles. The DRAM data is captured on the last of those cycles and shown on `rd_data`, with `rd_valid` high, in the following cycle.
- R4: A request with `req_len` = L performs exactly L+1 beats inside a single row activation. The first column is `req_addr[10:0]`, and each later beat uses the previous column plus one.
- R5: Column stepping wraps from 2047 to 0 within the same open row; the row never changes during a burst.
- R6: After the last beat both strobes go high, and the row strobe stays high for at least T_RP cycles before any later activation.
- R7: A refresh is requested every REF_PERIOD_CYC / 2^ROW_W cycles. A refresh holds `dram_ras_n` low for T_RCD cycles with no column strobe. When the controller is idle, refreshes start exactly that many cycles apart.
- R8: The refreshed row starts at 0 after reset and advances by one, modulo 2^ROW_W, after each refresh.
- R9: A pending refresh is started only from idle. If it is pending in the same cycle as a user request, the refresh goes first.
- R10: `req_ready` is low whenever a transaction or a refresh is in progress or a refresh is pending. A request that is held waits and is taken in the first idle cycle after the refresh's precharge.
- R11: `dram_we_n` and `dram_oe_n` are never low together, and `dram_cas_n` is low only while `dram_ras_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | ROW_W+COL_W | Word address, row in the upper part |
| req_len | input | LEN_W | Beats minus one |
| wr_data | input | DATA_W | Write data for the current beat |
| wr_pull | output | 1 | Current write beat consumes `wr_data` |
| rd_valid | output | 1 | `rd_data` holds a read beat |
| rd_data | output | DATA_W | Read beat data |
| dram_addr | output | max(ROW_W,COL_W) | Shared row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | DATA_W | Data driven to the DRAM |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | DATA_W | Data returned by the DRAM |

## Verification
The interval timer's refresh request and a fresh user request can reach the idle arbiter in the same cycle. The bench learns the timer phase from the start cycle of an idle refresh. It raises a read request in the exact cycle before the next refresh is due and checks that `req_ready` is low there. It then expects a column-free activation of the next pointer row, followed by the read being taken exactly T_RCD+T_RP+1 cycles later. Back-to-back mixed bursts also let refresh ticks land in the middle of transactions. Each activation is checked to hold the whole burst, with refresh spacing judged only between undisturbed refreshes.

// File: rtl/dram_burst_ctrl.sv
module dram_burst_ctrl #(
  parameter int ROW_W          = 11,
  parameter int COL_W          = 11,
  parameter int DATA_W         = 16,
  parameter int LEN_W          = 3,
  parameter int T_RCD          = 2,
  parameter int T_CL           = 2,
  parameter int T_RP           = 2,
  parameter int REF_PERIOD_CYC = 8_000_000
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         req_valid,
  output logic                                         req_ready,
  input  logic                                         req_write,
  input  logic [ROW_W+COL_W-1:0]                       req_addr,
  input  logic [LEN_W-1:0]                             req_len,
  input  logic [DATA_W-1:0]                            wr_data,
  output logic                                         wr_pull,
  output logic                                         rd_valid,
  output logic [DATA_W-1:0]                            rd_data,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic                                         dram_ras_n,
  output logic                                         dram_cas_n,
  output logic                                         dram_we_n,
  output logic                                         dram_oe_n,
  output logic [DATA_W-1:0]                            dram_dq_out,
  output logic                                         dram_dq_oe,
  input  logic [DATA_W-1:0]                            dram_dq_in
);
  localparam int PIN_W        = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int REF_INTERVAL = REF_PERIOD_CYC >> ROW_W;
  localparam int TMR_W        = (REF_INTERVAL > 2) ? $clog2(REF_INTERVAL) : 1;
  localparam int T_MAX0       = (T_RCD > T_CL) ? T_RCD : T_CL;
  localparam int T_MAX        = (T_MAX0 > T_RP) ? T_MAX0 : T_RP;
  localparam int CNT_W        = $clog2(T_MAX + 1);
  localparam logic [CNT_W-1:0] LD_RCD = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] LD_CL  = CNT_W'(T_CL - 1);
  localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 1);

  typedef enum logic [2:0] {S_IDLE, S_ROW, S_COL, S_PRE, S_REF} state_t;

  state_t            state;
  logic [CNT_W-1:0]  cnt;
  logic [ROW_W-1:0]  row_q;
  logic [ROW_W-1:0]  ref_row;
  logic [COL_W-1:0]  col_q;
  logic [LEN_W-1:0]  beats_left;
  logic              wr_q;
  logic              ref_pend;
  logic [TMR_W-1:0]  ref_tmr;

  wire              cnt_done = (cnt == '0);
  wire              in_col   = (state == S_COL);
  wire [CNT_W-1:0]  ld_beat  = wr_q ? '0 : LD_CL;
  wire              grant_ref = (state == S_IDLE) && ref_pend;

  assign req_ready   = (state == S_IDLE) && !ref_pend;
  assign dram_ras_n  = !(state == S_ROW || state == S_COL || state == S_REF);
  assign dram_cas_n  = !in_col;
  assign wr_pull     = in_col && wr_q;
  assign dram_we_n   = !wr_pull;
  assign dram_oe_n   = !(in_col && !wr_q);
  assign dram_dq_oe  = wr_pull;
  assign dram_dq_out = wr_data;

  always_comb begin
    case (state)
      S_ROW:   dram_addr = PIN_W'(row_q);
      S_REF:   dram_addr = PIN_W'(ref_row);
      S_COL:   dram_addr = PIN_W'(col_q);
      default: dram_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_tmr  <= '0;
      ref_pend <= 1'b0;
    end else begin
      if (grant_ref) ref_pend <= 1'b0;
      if (ref_tmr == TMR_W'(REF_INTERVAL - 1)) begin
        ref_tmr  <= '0;
        ref_pend <= 1'b1;
      end else begin
        ref_tmr <= ref_tmr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      row_q      <= '0;
      col_q      <= '0;
      ref_row    <= '0;
      beats_left <= '0;
      wr_q       <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
    end else begin
      rd_valid <= in_col && !wr_q && cnt_done;
      if (in_col && !wr_q && cnt_done) rd_data <= dram_dq_in;
      case (state)
        S_IDLE: begin
          if (ref_pend) begin
            state <= S_REF;
            cnt   <= LD_RCD;
          end else if (req_valid) begin
            state      <= S_ROW;
            cnt        <= LD_RCD;
            row_q      <= req_addr[ROW_W+COL_W-1:COL_W];
            col_q      <= req_addr[COL_W-1:0];
            beats_left <= req_len;
            wr_q       <= req_write;
          end
        end
        S_ROW: begin
          if (cnt_done) begin
            state <= S_COL;
            cnt   <= ld_beat;
          end else cnt <= cnt - 1'b1;
        end
        S_COL: begin
          if (cnt_done) begin
            if (beats_left == '0) begin
              state <= S_PRE;
              cnt   <= LD_RP;
            end else begin
              col_q      <= col_q + 1'b1;
              beats_left <= beats_left - 1'b1;
              cnt        <= ld_beat;
            end
          end else cnt <= cnt - 1'b1;
        end
        S_REF: begin
          if (cnt_done) begin
            state   <= S_PRE;
            cnt     <= LD_RP;
            ref_row <= ref_row + 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        S_PRE: begin
          if (cnt_done) state <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dram_burst_ctrl_chk.sv
module dram_burst_ctrl_chk #(
  parameter int T_RCD = 2,
  parameter int T_RP  = 2,
  parameter int COL_W = 11,
  parameter int PIN_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rd_valid,
  input logic [PIN_W-1:0] dram_addr,
  input logic             dram_ras_n,
  input logic             dram_cas_n,
  input logic             dram_we_n,
  input logic             dram_oe_n
);
  logic [7:0] lo_cnt;
  logic [7:0] hi_cnt;
  logic       cas_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_cnt   <= '0;
      hi_cnt   <= 8'hFF;
      cas_seen <= 1'b0;
    end else begin
      lo_cnt   <= dram_ras_n ? 8'd0 : ((lo_cnt == 8'hFF) ? lo_cnt : lo_cnt + 8'd1);
      hi_cnt   <= !dram_ras_n ? 8'd0 : ((hi_cnt == 8'hFF) ? hi_cnt : hi_cnt + 8'd1);
      cas_seen <= dram_ras_n ? 1'b0 : (cas_seen | !dram_cas_n);
    end
  end

  a_r11_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);

  a_r11_we_oe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> dram_oe_n);

  a_r2_rcd_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_cas_n && !cas_seen) |-> (lo_cnt == 8'(T_RCD)));

  a_r6_precharge_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (hi_cnt >= 8'(T_RP)));

  a_r4_col_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_cas_n && $past(!dram_cas_n) && dram_addr != $past(dram_addr))
      |-> dram_addr[COL_W-1:0] == COL_W'($past(dram_addr[COL_W-1:0]) + 1'b1));

  a_r10_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (dram_ras_n && dram_cas_n));

  a_r3_read_follows_cas: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!dram_cas_n && !dram_oe_n));
endmodule

bind dram_burst_ctrl dram_burst_ctrl_chk #(
  .T_RCD(T_RCD), .T_RP(T_RP), .COL_W(COL_W), .PIN_W(PIN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rd_valid(rd_valid),
  .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
  .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n)
);

// File: tb/dram_burst_ctrl_bench.sv
module dram_burst_ctrl_bench;
  localparam int ROW_W    = 11;
  localparam int COL_W    = 11;
  localparam int DW       = 16;
  localparam int LW       = 3;
  localparam int RCD      = 3;
  localparam int CL       = 2;
  localparam int RP       = 2;
  localparam int INTERVAL = 64;
  localparam int NCOL     = 1 << COL_W;
  localparam int NROW     = 1 << ROW_W;

  typedef struct { bit wr; int row; int col; int len; } tx_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [ROW_W+COL_W-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] dram_dq_in = '0;
  logic req_ready, wr_pull, rd_valid, dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [DW-1:0] rd_data, dram_dq_out;
  logic [ROW_W-1:0] dram_addr;

  int checks = 0, errors = 0, cyc = 0;
  int wbase = 0, wr_idx = 0;
  tx_t txq[$];
  int exp_rd[$];
  int golden[int];
  int mem[int];

  int open_row = 0, act_row = 0, act_start = 0, cas_cyc = 0, beats = 0, first_cas = -1;
  int hi_cnt = 1000, prev_addr = 0, exp_ref_row = 0, ref_count = 0, last_ref_start = -1;
  bit prev_ras = 1, prev_cas = 1, user_since = 0, prev_gap_clean = 1;
  int acc_cyc = 0;

  assign wr_data = DW'(wbase + wr_idx);

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_burst_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DW), .LEN_W(LW),
    .T_RCD(RCD), .T_CL(CL), .T_RP(RP), .REF_PERIOD_CYC(INTERVAL * NROW)
  ) u_dram_burst_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .wr_data(wr_data), .wr_pull(wr_pull), .rd_valid(rd_valid), .rd_data(rd_data),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // Behavioural DRAM array plus a reference model of the pin sequence.
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_ras = 1; prev_cas = 1; hi_cnt = 1000;
    end else begin
      chk(!( !dram_we_n && !dram_oe_n) && !(!dram_cas_n && dram_ras_n), "R11",
          "strobe combination", {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 0);
      if (!dram_ras_n && prev_ras) begin
        chk(hi_cnt >= RP, "R6", "precharge cycles before activation", hi_cnt, RP);
        open_row = int'(dram_addr); act_row = open_row; act_start = cyc;
        cas_cyc = 0; beats = 0; first_cas = -1;
      end
      if (!dram_cas_n) begin
        int key;
        cas_cyc++;
        if (prev_cas || int'(dram_addr) != prev_addr) begin
          if (txq.size() == 0) chk(0, "R4", "column access without a transaction", 1, 0);
          else begin
            int ec;
            ec = (txq[0].col + beats) % NCOL;
            chk(int'(dram_addr) == ec, (txq[0].col + beats >= NCOL) ? "R5" : "R4",
                "beat column", int'(dram_addr), ec);
            if (beats == 0) first_cas = cyc - act_start;
          end
          beats++;
        end
        key = open_row * NCOL + int'(dram_addr);
        if (!dram_we_n) begin
          chk(dram_dq_oe && wr_pull, "R3", "write drive enable", dram_dq_oe, 1);
          mem[key] = int'(dram_dq_out);
        end
        if (!dram_oe_n) dram_dq_in = mem.exists(key) ? DW'(mem[key]) : '0;
        if (wr_pull) wr_idx++;
      end
      if (dram_ras_n && !prev_ras) begin
        int dur;
        dur = cyc - act_start;
        if (beats == 0) begin
          bit gap_clean;
          chk(act_row == exp_ref_row, "R8", "refresh row", act_row, exp_ref_row);
          chk(dur == RCD, "R7", "refresh row strobe width", dur, RCD);
          gap_clean = !user_since;
          if (last_ref_start >= 0 && gap_clean && prev_gap_clean)
            chk(act_start - last_ref_start == INTERVAL, "R7", "idle refresh spacing",
                act_start - last_ref_start, INTERVAL);
          prev_gap_clean = gap_clean;
          last_ref_start = act_start;
          ref_count++;
          exp_ref_row = (exp_ref_row + 1) % NROW;
          user_since = 0;
        end else if (txq.size() != 0) begin
          tx_t t;
          t = txq.pop_front();
          chk(act_row == t.row, "R2", "activated row", act_row, t.row);
          chk(first_cas == RCD, "R2", "row to column delay", first_cas, RCD);
          chk(beats == t.len + 1, "R4", "beats in one activation", beats, t.len + 1);
          chk(cas_cyc == beats * (t.wr ? 1 : CL), "R3", "column strobe cycles",
              cas_cyc, beats * (t.wr ? 1 : CL));
          user_since = 1;
        end
      end
      if (rd_valid) begin
        if (exp_rd.size() == 0) chk(0, "R3", "unexpected read beat", int'(rd_data), -1);
        else begin
          int e;
          e = exp_rd.pop_front();
          chk(int'(rd_data) == e, "R3", "read beat data", int'(rd_data), e);
        end
      end
      hi_cnt = dram_ras_n ? hi_cnt + 1 : 0;
      prev_ras = dram_ras_n; prev_cas = dram_cas_n; prev_addr = int'(dram_addr);
    end
  end

  // Call at a negedge; returns one time unit after the accepting edge.
  task automatic issue(bit wr, int row, int col, int len, int base);
    tx_t t;
    req_write = wr;
    req_addr  = {row[ROW_W-1:0], col[COL_W-1:0]};
    req_len   = len[LW-1:0];
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    acc_cyc = cyc;
    t.wr = wr; t.row = row; t.col = col; t.len = len;
    txq.push_back(t);
    for (int b = 0; b <= len; b++) begin
      int k;
      k = row * NCOL + (col + b) % NCOL;
      if (wr) golden[k] = (base + b) & ((1 << DW) - 1);
      else exp_rd.push_back(golden.exists(k) ? golden[k] : 0);
    end
    if (wr) begin wbase = base; wr_idx = 0; end
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (txq.size() != 0 || exp_rd.size() != 0 || !req_ready) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog: actual %0d cycles expected completion", cyc);
    summary();
    $finish;
  end

  initial begin
    int target, r0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1", "strobes after reset",
        {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
    chk(!rd_valid && !wr_pull, "R1", "data flags after reset", {rd_valid, wr_pull}, 0);
    chk(req_ready, "R1", "ready after reset", req_ready, 1);

    issue(1, 5, 10, 3, 'h100);
    @(negedge clk) issue(0, 5, 10, 3, 0);
    drain();
    // R5: burst running off the last column wraps within row 7
    issue(1, 7, 2045, 7, 'h200);
    @(negedge clk) issue(0, 7, 2045, 7, 0);
    @(negedge clk) issue(0, 7, 0, 1, 0);
    @(negedge clk) issue(1, 2047, 2047, 0, 'h3A5);
    @(negedge clk) issue(0, 2047, 2047, 0, 0);
    drain();

    // R7 R8: idle refresh cadence
    repeat (4 * INTERVAL + 8) @(negedge clk);

    // R9 R10: request raised in the cycle the refresh becomes pending
    target = last_ref_start + INTERVAL - 1;
    while (target <= cyc) target += INTERVAL;
    while (cyc < target) @(negedge clk);
    chk(!req_ready, "R10", "ready while refresh pending", req_ready, 0);
    r0 = ref_count;
    issue(0, 5, 11, 0, 0);
    chk(ref_count == r0 + 1, "R9", "refresh served before request", ref_count, r0 + 1);
    chk(acc_cyc - target == RCD + RP + 1, "R10", "request wait cycles",
        acc_cyc - target, RCD + RP + 1);
    drain();

    // mixed back-to-back traffic crossing several refresh ticks
    for (int i = 0; i < 12; i++) begin
      @(negedge clk) issue(1, (i * 37) % NROW, (2040 + i * 3) % NCOL, i % 8, 'h1000 + i * 16);
    end
    for (int i = 0; i < 12; i++) begin
      @(negedge clk) issue(0, (i * 37) % NROW, (2040 + i * 3) % NCOL, i % 8, 0);
    end
    drain();
    repeat (INTERVAL) @(negedge clk);
    chk(txq.size() == 0 && exp_rd.size() == 0, "R4", "all transactions completed",
        txq.size() + exp_rd.size(), 0);
    chk(ref_count > 8, "R7", "refreshes seen", ref_count, 9);
    summary();
    $finish;
  end
endmodule